// File: doc/BRIEF.md
# Serial Receive Engine with Error and Break Flags

This block takes an asynchronous serial line and turns each frame of one start bit, eight data bits and one stop bit into a byte. The line is sampled on a sixteen-times-baud tick that is supplied from outside. When a byte arrives it is placed on `rx_byte` and the receive flag goes high. Software lowers that flag with a one-cycle clear strobe.

Three error flags record problems on the line, and each stays set until its own clear strobe. The frame flag reports a missing stop bit. The break flag reports a line held low for eleven bit times. The overrun flag reports a byte that completed while the previous one was still unread. One interrupt request line carries the receive flag. It can also carry a transmit flag supplied from outside when the shared mode is selected, and the error flags when the status enable is set.

Top module: `serial_rx_guard`

## Requirements
- R1: Frames are 8N1 with the least significant bit first, sampled at mid-bit on `os_tick` (16 ticks per bit). When the stop bit is sampled, the byte appears on `rx_byte` and `rx_flag` goes to 1.
- R2: A start bit is accepted only if `rxd` is still low 8 ticks after the falling edge is seen. A shorter low pulse delivers no byte.
- R3: `rx_flag` stays 1 until a `rx_flag_clr` pulse. A clear in the same cycle as a frame completion takes effect before that completion is judged.
- R4: A stop bit sampled low sets `frm_err`. The byte is still delivered. The flag stays set until `frm_err_clr`.
- R5: `brk_det` sets once `rxd` has been low for 176 consecutive ticks (11 bit times). A 0x00 frame with a valid stop bit (9 bit times low) does not set it. The flag stays set until `brk_det_clr`.
- R6: If a frame completes while `rx_flag` is 1, `ovr_err` sets, `rx_byte` keeps the unread byte and the new byte is dropped. The flag stays set until `ovr_err_clr`.
- R7: `irq` = `rx_flag` OR (`tx_flag` when `irq_split`=0) OR (`stat_irq_en` AND any of `frm_err`, `brk_det`, `ovr_err`).
- R8: After reset, `rx_byte` is 0x00 and every flag and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idle high |
| rx_flag_clr | input | 1 | Clears the receive flag |
| frm_err_clr | input | 1 | Clears the framing flag |
| brk_det_clr | input | 1 | Clears the break flag |
| ovr_err_clr | input | 1 | Clears the overrun flag |
| stat_irq_en | input | 1 | Lets the error flags drive irq |
| irq_split | input | 1 | 1: irq is receive-only; 0: tx_flag is also merged |
| tx_flag | input | 1 | Transmit flag from the companion transmitter |
| rx_byte | output | 8 | Last accepted byte |
| rx_flag | output | 1 | Byte-ready flag |
| frm_err | output | 1 | Sticky framing error |
| brk_det | output | 1 | Sticky break detect |
| ovr_err | output | 1 | Sticky overrun |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends bytes with alternating and single-bit patterns, so that a reversed bit order or a sample point one bit off shows up as a wrong byte. It sends a 0x00 frame with a good stop bit, which a break counter that is too short would flag. It also holds the line low for twelve bit times, which a counter that is too long or is reset by the frame logic would miss. Two unread frames in a row show whether overrun overwrites the stored byte. A three-tick glitch shows whether the start bit is confirmed at all. Finally, the status enable and split settings are switched on their own, to catch an interrupt that ignores them.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP  = 3'd3,
    RX_HOLD  = 3'd4
  } rx_state_t;
endpackage

// File: rtl/rst_release.sv
module rst_release (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_sn  <= stage_q;
    end
  end
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             os_tick,
  input  logic             rxd,
  output logic             rxd_s,
  output logic             frame_done,
  output logic             stop_ok,
  output logic [DBITS-1:0] frame_byte
);
  localparam int TW = $clog2(OSR);
  localparam int BW = (DBITS > 1) ? $clog2(DBITS) : 1;
  localparam logic [TW-1:0] T_MID  = TW'(OSR/2 - 1);
  localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DBITS - 1);

  rx_state_t        st_q, st_n;
  logic [TW-1:0]    tcnt_q, tcnt_n;
  logic [BW-1:0]    bcnt_q, bcnt_n;
  logic [DBITS-1:0] sh_q, sh_n;
  logic             meta_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      meta_q <= 1'b1;
      rxd_s  <= 1'b1;
    end else begin
      meta_q <= rxd;
      rxd_s  <= meta_q;
    end
  end

  always_comb begin
    st_n       = st_q;
    tcnt_n     = tcnt_q;
    bcnt_n     = bcnt_q;
    sh_n       = sh_q;
    frame_done = 1'b0;
    stop_ok    = rxd_s;
    if (os_tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rxd_s) begin
            st_n   = RX_START;
            tcnt_n = '0;
          end
        end
        RX_START: begin
          if (tcnt_q == T_MID) begin
            tcnt_n = '0;
            bcnt_n = '0;
            st_n   = rxd_s ? RX_IDLE : RX_DATA;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (tcnt_q == T_LAST) begin
            tcnt_n = '0;
            sh_n   = {rxd_s, sh_q[DBITS-1:1]};
            if (bcnt_q == B_LAST) st_n = RX_STOP;
            else                  bcnt_n = bcnt_q + 1'b1;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tcnt_q == T_LAST) begin
            frame_done = 1'b1;
            st_n       = rxd_s ? RX_IDLE : RX_HOLD;
          end else begin
            tcnt_n = tcnt_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (rxd_s) st_n = RX_IDLE;
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= RX_IDLE;
      tcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_n;
      tcnt_q <= tcnt_n;
      bcnt_q <= bcnt_n;
      sh_q   <= sh_n;
    end
  end

  assign frame_byte = sh_q;

  // R1: a completion is a single-cycle event
  p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_done |=> !frame_done);

  // R2: data sampling begins only after a low mid-start sample
  p_start_confirmed_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == RX_START && st_n == RX_DATA) |-> !rxd_s);
endmodule

// File: rtl/brk_watch.sv
module brk_watch #(
  parameter int OSR        = 16,
  parameter int BREAK_BITS = 11
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic os_tick,
  input  logic rxd_s,
  output logic brk_hit
);
  localparam int LIMIT = OSR * BREAK_BITS;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] C_LIM = CW'(LIMIT);

  logic [CW-1:0] low_q, low_n;

  always_comb begin
    low_n   = low_q;
    brk_hit = 1'b0;
    if (os_tick) begin
      if (rxd_s) begin
        low_n = '0;
      end else if (low_q != C_LIM) begin
        low_n   = low_q + 1'b1;
        brk_hit = (low_q == C_LIM - 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) low_q <= '0;
    else         low_q <= low_n;
  end

  // R5: a break can only be reported while the line is low
  p_brk_line_low_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    brk_hit |-> !rxd_s);
endmodule

// File: rtl/serial_rx_guard.sv
module serial_rx_guard #(
  parameter int OSR        = 16,
  parameter int DBITS      = 8,
  parameter int BREAK_BITS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             os_tick,
  input  logic             rxd,
  input  logic             rx_flag_clr,
  input  logic             frm_err_clr,
  input  logic             brk_det_clr,
  input  logic             ovr_err_clr,
  input  logic             stat_irq_en,
  input  logic             irq_split,
  input  logic             tx_flag,
  output logic [DBITS-1:0] rx_byte,
  output logic             rx_flag,
  output logic             frm_err,
  output logic             brk_det,
  output logic             ovr_err,
  output logic             irq
);
  logic             rst_sn;
  logic             rxd_s, frame_done, stop_ok, brk_hit;
  logic [DBITS-1:0] frame_byte;
  logic [DBITS-1:0] byte_n;
  logic             rxf_n, fe_n, brk_n, ovr_n, rx_keep;

  rst_release u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  rx_frame #(.OSR(OSR), .DBITS(DBITS)) u_frame (
    .clk(clk), .rst_sn(rst_sn), .os_tick(os_tick), .rxd(rxd),
    .rxd_s(rxd_s), .frame_done(frame_done), .stop_ok(stop_ok),
    .frame_byte(frame_byte)
  );

  brk_watch #(.OSR(OSR), .BREAK_BITS(BREAK_BITS)) u_brk (
    .clk(clk), .rst_sn(rst_sn), .os_tick(os_tick), .rxd_s(rxd_s),
    .brk_hit(brk_hit)
  );

  always_comb begin
    rx_keep = rx_flag & ~rx_flag_clr;
    rxf_n   = rx_keep;
    byte_n  = rx_byte;
    ovr_n   = ovr_err & ~ovr_err_clr;
    fe_n    = frm_err & ~frm_err_clr;
    brk_n   = (brk_det & ~brk_det_clr) | brk_hit;
    if (frame_done) begin
      if (!stop_ok) fe_n = 1'b1;
      if (rx_keep) begin
        ovr_n = 1'b1;
      end else begin
        rxf_n  = 1'b1;
        byte_n = frame_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rx_byte <= '0;
      rx_flag <= 1'b0;
      frm_err <= 1'b0;
      brk_det <= 1'b0;
      ovr_err <= 1'b0;
    end else begin
      rx_byte <= byte_n;
      rx_flag <= rxf_n;
      frm_err <= fe_n;
      brk_det <= brk_n;
      ovr_err <= ovr_n;
    end
  end

  assign irq = rx_flag | (~irq_split & tx_flag)
             | (stat_irq_en & (frm_err | brk_det | ovr_err));

  // R3: the receive flag only drops after a clear strobe
  p_rxflag_hold_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(rx_flag) |-> $past(rx_flag_clr));
  // R4: framing flag is sticky
  p_fe_sticky_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(frm_err) |-> $past(frm_err_clr));
  // R5: break flag is sticky
  p_brk_sticky_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(brk_det) |-> $past(brk_det_clr));
  // R6: an overrun never replaces the unread byte
  p_ovr_keeps_byte_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(ovr_err) |-> $stable(rx_byte));
  // R7: with no flag source active the request is low
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!rx_flag && (irq_split || !tx_flag) && !stat_irq_en) |-> !irq);
endmodule

// File: tb/serial_rx_guard_bench.sv
module serial_rx_guard_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       rx_flag_clr = 1'b0, frm_err_clr = 1'b0;
  logic       brk_det_clr = 1'b0, ovr_err_clr = 1'b0;
  logic       stat_irq_en = 1'b0, irq_split = 1'b1, tx_flag = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_flag, frm_err, brk_det, ovr_err, irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit prev_rxf = 0;
  logic [7:0] expq[$];

  always #10 clk = ~clk;

  serial_rx_guard u_serial_rx_guard (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .rx_flag_clr(rx_flag_clr), .frm_err_clr(frm_err_clr),
    .brk_det_clr(brk_det_clr), .ovr_err_clr(ovr_err_clr),
    .stat_irq_en(stat_irq_en), .irq_split(irq_split), .tx_flag(tx_flag),
    .rx_byte(rx_byte), .rx_flag(rx_flag), .frm_err(frm_err),
    .brk_det(brk_det), .ovr_err(ovr_err), .irq(irq)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each rising receive flag (R1)
  always @(negedge clk) begin
    if (rst_n && rx_flag && !prev_rxf) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1: actual byte %h expected none", rx_byte);
      end else begin
        chk("R1", rx_byte, expq.pop_front());
      end
    end
    prev_rxf = rx_flag;
  end

  task automatic bitp(input logic v, input int n);
    rxd = v;
    repeat (64 * n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stop, input bit expect_it);
    if (expect_it) expq.push_back(b);
    bitp(1'b0, 1);
    for (int i = 0; i < 8; i++) bitp(b[i], 1);
    bitp(stop, 1);
    bitp(1'b1, 2);
  endtask

  task automatic strobe(input int which);
    case (which)
      0: rx_flag_clr = 1'b1;
      1: frm_err_clr = 1'b1;
      2: brk_det_clr = 1'b1;
      default: ovr_err_clr = 1'b1;
    endcase
    @(negedge clk);
    rx_flag_clr = 1'b0; frm_err_clr = 1'b0;
    brk_det_clr = 1'b0; ovr_err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R8 reset state
    chk("R8", rx_byte, 8'h00);
    chk("R8", {3'b0, rx_flag, frm_err, brk_det, ovr_err, irq}, 8'h00);

    // R1 several patterns, R3 clear, R7 irq from rx_flag
    send(8'hA5, 1'b1, 1);
    chk("R3", {7'b0, rx_flag}, 8'h01);
    chk("R7", {7'b0, irq}, 8'h01);
    chk("R4", {7'b0, frm_err}, 8'h00);
    strobe(0);
    chk("R3", {7'b0, rx_flag}, 8'h00);
    send(8'h3C, 1'b1, 1); strobe(0);
    send(8'h01, 1'b1, 1); strobe(0);
    send(8'h80, 1'b1, 1); strobe(0);

    // R2 short glitch ignored
    bitp(1'b0, 0); rxd = 1'b0; repeat (12) @(negedge clk); rxd = 1'b1;
    bitp(1'b1, 12);
    chk("R2", {7'b0, rx_flag}, 8'h00);

    // R5 0x00 frame with good stop does not raise break
    send(8'h00, 1'b1, 1);
    chk("R5", {7'b0, brk_det}, 8'h00);
    strobe(0);

    // R4 bad stop
    send(8'h55, 1'b0, 1);
    chk("R4", {7'b0, frm_err}, 8'h01);
    chk("R4", rx_byte, 8'h55);
    strobe(0);
    stat_irq_en = 1'b0; @(negedge clk);
    chk("R7", {7'b0, irq}, 8'h00);
    stat_irq_en = 1'b1; @(negedge clk);
    chk("R7", {7'b0, irq}, 8'h01);
    stat_irq_en = 1'b0;
    strobe(1);
    chk("R4", {7'b0, frm_err}, 8'h00);

    // R6 overrun keeps the unread byte
    send(8'h11, 1'b1, 1);
    send(8'h22, 1'b1, 0);
    chk("R6", {7'b0, ovr_err}, 8'h01);
    chk("R6", rx_byte, 8'h11);
    strobe(0); strobe(3);
    chk("R6", {7'b0, ovr_err}, 8'h00);

    // R5 break: 12 bit times low
    expq.push_back(8'h00);
    bitp(1'b0, 12);
    bitp(1'b1, 3);
    chk("R5", {7'b0, brk_det}, 8'h01);
    chk("R4", {7'b0, frm_err}, 8'h01);
    strobe(0); strobe(1);
    chk("R5", {7'b0, brk_det}, 8'h01);
    strobe(2);
    chk("R5", {7'b0, brk_det}, 8'h00);

    // R7 split selection
    tx_flag = 1'b1; irq_split = 1'b0; @(negedge clk);
    chk("R7", {7'b0, irq}, 8'h01);
    irq_split = 1'b1; @(negedge clk);
    chk("R7", {7'b0, irq}, 8'h00);
    tx_flag = 1'b0;

    chk("R1", expq.size(), 8'd0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule